// File: doc/BRIEF.md
# Single-Cycle Integer ALU

This block is the integer arithmetic and logic unit of a small load/store CPU datapath. It has no clock and no state. Two 32-bit two's complement operands enter. An adder/subtractor and a bitwise logic unit both work on them in parallel, and a four-way result selector picks what drives the result bus. The selector can pass the second operand straight through, which serves load-upper-immediate after an external shifter. It can also pick a set-less-than word, the arithmetic result or the logic result.

Two flags come out next to the result. The zero flag and the set-less-than bit are always taken from the adder/subtractor, whatever the selector picks. The overflow flag reports two's complement overflow of the current add or subtract. Both flags are driven for every selector value, and the consumer decides when they matter. The block does not force subtraction for set-less-than. The controller must drive the subtract bit high for that result to mean x < y.

Top module: `int_alu`

## Requirements
- R1: With sel_op = 2'b10 and sub_en = 0, result equals x + y modulo 2^32.
- R2: With sel_op = 2'b10 and sub_en = 1, result equals x − y modulo 2^32.
- R3: With sel_op = 2'b11, result is the bitwise function of x and y picked by bit_op: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOR.
- R4: With sel_op = 2'b00, result equals y unchanged, whatever sub_en and bit_op are.
- R5: With sel_op = 2'b01, result bits 31..1 are zero and bit 0 is the raw sign bit of the adder/subtractor output. No overflow correction is applied, so 0x80000000 − 1 gives 0.
- R6: is_zero is 1 exactly when all 32 bits of the adder/subtractor output are 0, for every sel_op value and independent of the selected result.
- R7: For addition, ovf is 1 exactly when x and y share a sign and the sum's sign differs from it (0x7FFFFFFF + 1 gives 1).
- R8: For subtraction, ovf is 1 exactly when x and y differ in sign and the difference's sign differs from x's (0x80000000 − 1 gives 1, 0x80000000 − 0x80000000 gives 0).
- R9: is_zero and ovf follow the adder/subtractor for every sel_op value, including the pass-through and logic selections.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 32 | First operand, two's complement |
| y | input | 32 | Second operand, two's complement |
| sub_en | input | 1 | 0 adds, 1 subtracts y from x |
| bit_op | input | 2 | Bitwise function select for the logic unit |
| sel_op | input | 2 | Result source select |
| result | output | 32 | Selected result |
| ovf | output | 1 | Two's complement overflow of the add/subtract |
| is_zero | output | 1 | Adder/subtractor output is all zeros |

## Verification
The flags are hard to observe because they track the adder while the result bus may show something else. The hardest case is set-less-than under overflow, where the sign bit gives the wrong ordering on purpose. The stimulus drives 0x80000000 − 1 with the set-less-than selection and expects result 0 with ovf set. It also drives equal operands under the pass-through selection, so that is_zero rises while result is nonzero. A sweep then runs every control combination over boundary operand pairs against a reference built from 33-bit sign-extended arithmetic.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_PASS_Y = 2'b00,
    SEL_SLT    = 2'b01,
    SEL_ARITH  = 2'b10,
    SEL_LOGIC  = 2'b11
  } sel_op_e;

  typedef enum logic [1:0] {
    BIT_AND = 2'b00,
    BIT_OR  = 2'b01,
    BIT_XOR = 2'b10,
    BIT_NOR = 2'b11
  } bit_op_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  // subtraction as a + ~b + 1
  assign b_eff = b ^ {W{sub}};
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = full[W-1:0];

  // sign rule: the effective operands agree in sign and the outcome does not
  assign ovf = ~(a[W-1] ^ b_eff[W-1]) & (a[W-1] ^ sum[W-1]);
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  output logic [W-1:0] q
);
  import int_alu_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (bit_op_e'(op))
        BIT_AND: q[i] = a[i] & b[i];
        BIT_OR:  q[i] = a[i] | b[i];
        BIT_XOR: q[i] = a[i] ^ b[i];
        default: q[i] = ~(a[i] | b[i]);
      endcase
    end
  end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int unsigned W = int_alu_pkg::DATA_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub_en,
  input  logic [1:0]   bit_op,
  input  logic [1:0]   sel_op,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         is_zero
);
  import int_alu_pkg::*;

  logic [W-1:0] as_sum;
  logic [W-1:0] lg_q;
  logic [W-1:0] slt_word;

  int_alu_addsub #(.W(W)) u_addsub (
    .a   (x),
    .b   (y),
    .sub (sub_en),
    .sum (as_sum),
    .ovf (ovf)
  );

  int_alu_logic #(.W(W)) u_logic (
    .a  (x),
    .b  (y),
    .op (bit_op),
    .q  (lg_q)
  );

  assign slt_word = {{(W-1){1'b0}}, as_sum[W-1]};
  assign is_zero  = ~|as_sum;

  always_comb begin
    unique case (sel_op_e'(sel_op))
      SEL_PASS_Y: result = y;
      SEL_SLT:    result = slt_word;
      SEL_ARITH:  result = as_sum;
      default:    result = lg_q;
    endcase
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] x,
  input logic [W-1:0] y,
  input logic         sub_en,
  input logic [1:0]   bit_op,
  input logic [1:0]   sel_op,
  input logic [W-1:0] result,
  input logic         ovf,
  input logic         is_zero
);
  logic signed [W:0] wide;
  logic [W-1:0]      nar;

  always_comb begin
    wide = sub_en ? ($signed({x[W-1], x}) - $signed({y[W-1], y}))
                  : ($signed({x[W-1], x}) + $signed({y[W-1], y}));
    nar  = wide[W-1:0];
  end

  always_comb begin
    if (sel_op == 2'b10 && !sub_en)
      p_add_r1: assert (result == x + y);
    if (sel_op == 2'b10 && sub_en)
      p_sub_r2: assert (result == x - y);
    if (sel_op == 2'b11 && bit_op == 2'b11)
      p_nor_r3: assert (result == ~(x | y));
    if (sel_op == 2'b00)
      p_pass_r4: assert (result == y);
    if (sel_op == 2'b01)
      p_slt_r5: assert (result[W-1:1] == '0 && result[0] == nar[W-1]);
    p_zero_r6: assert (is_zero == (nar == '0));
    if (!sub_en)
      p_ovf_add_r7: assert (ovf == (wide[W] ^ wide[W-1]));
    if (sub_en)
      p_ovf_sub_r8: assert (ovf == (wide[W] ^ wide[W-1]));
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .x(x), .y(y), .sub_en(sub_en), .bit_op(bit_op), .sel_op(sel_op),
  .result(result), .ovf(ovf), .is_zero(is_zero)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic [31:0] x, y, result;
  logic        sub_en, ovf, is_zero;
  logic [1:0]  bit_op, sel_op;

  int_alu dut (
    .x(x), .y(y), .sub_en(sub_en), .bit_op(bit_op), .sel_op(sel_op),
    .result(result), .ovf(ovf), .is_zero(is_zero)
  );

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [31:0] vx;
    logic [31:0] vy;
    logic        vs;
    logic [1:0]  vb;
    logic [1:0]  vf;
    logic [31:0] er;
    logic        ez;
    logic        eo;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h7FFFFFFF, 32'h00000001, 1'b0, 2'b00, 2'b10, 32'h80000000, 1'b0, 1'b1, 4'd7}, // R7 R1
    '{32'h80000000, 32'h00000001, 1'b1, 2'b00, 2'b10, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd8}, // R8 R2
    '{32'h80000000, 32'h80000000, 1'b1, 2'b00, 2'b10, 32'h00000000, 1'b1, 1'b0, 4'd8}, // R8 R6
    '{32'h00000005, 32'h00000005, 1'b1, 2'b00, 2'b01, 32'h00000000, 1'b1, 1'b0, 4'd5}, // R5
    '{32'h00000003, 32'h00000007, 1'b1, 2'b00, 2'b01, 32'h00000001, 1'b0, 1'b0, 4'd5}, // R5
    '{32'h80000000, 32'h00000001, 1'b1, 2'b00, 2'b01, 32'h00000000, 1'b0, 1'b1, 4'd5}, // R5 raw sign
    '{32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 2'b00, 2'b11, 32'hF000F000, 1'b0, 1'b0, 4'd3}, // R3 AND
    '{32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 2'b01, 2'b11, 32'hFFF0FFF0, 1'b0, 1'b0, 4'd3}, // R3 OR
    '{32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 2'b10, 2'b11, 32'h0FF00FF0, 1'b0, 1'b0, 4'd3}, // R3 XOR
    '{32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 2'b11, 2'b11, 32'h000F000F, 1'b0, 1'b0, 4'd3}, // R3 NOR
    '{32'h00001234, 32'hABCD0000, 1'b1, 2'b10, 2'b00, 32'hABCD0000, 1'b0, 1'b0, 4'd4}, // R4
    '{32'h00000055, 32'h00000055, 1'b1, 2'b01, 2'b00, 32'h00000055, 1'b1, 1'b0, 4'd6}, // R6
    '{32'h7FFFFFFF, 32'h00000001, 1'b0, 2'b00, 2'b00, 32'h00000001, 1'b0, 1'b1, 4'd9}  // R9
  };

  task automatic cmp1(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ax, input logic [31:0] ay, input logic as,
                       input logic [1:0] ab, input logic [1:0] af);
    @(negedge clk);
    x = ax; y = ay; sub_en = as; bit_op = ab; sel_op = af;
    #5;
  endtask

  function automatic void ref_model(input logic [31:0] ax, input logic [31:0] ay, input logic as,
                                    input logic [1:0] ab, input logic [1:0] af,
                                    output logic [31:0] r, output logic z, output logic o);
    logic signed [32:0] w;
    w = as ? ($signed({ax[31], ax}) - $signed({ay[31], ay}))
           : ($signed({ax[31], ax}) + $signed({ay[31], ay}));
    o = w[32] ^ w[31];
    z = (w[31:0] == 32'd0);
    case (af)
      2'b00: r = ay;
      2'b01: r = {31'd0, w[31]};
      2'b10: r = w[31:0];
      default: case (ab)
        2'b00: r = ax & ay;
        2'b01: r = ax | ay;
        2'b10: r = ax ^ ay;
        default: r = ~(ax | ay);
      endcase
    endcase
  endfunction

  initial begin
    x = '0; y = '0; sub_en = 1'b0; bit_op = 2'b00; sel_op = 2'b00;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // idle inputs: pass-through of zero, adder output zero (R4, R6)
    #5;
    cmp1("idle result", 4, result, 32'd0);
    cmp1("idle zero", 6, {31'd0, is_zero}, 32'd1);
    cmp1("idle ovf", 7, {31'd0, ovf}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].vx, VECS[i].vy, VECS[i].vs, VECS[i].vb, VECS[i].vf);
      cmp1("result", int'(VECS[i].req), result, VECS[i].er);
      cmp1("is_zero", 6, {31'd0, is_zero}, {31'd0, VECS[i].ez});
      cmp1("ovf", VECS[i].vs ? 8 : 7, {31'd0, ovf}, {31'd0, VECS[i].eo});
    end

    // sweep: every control combination over boundary operand pairs (R1 R2 R3 R4 R5 R6 R7 R8 R9)
    begin
      logic [31:0] px [6] = '{32'h7FFFFFFF, 32'h80000000, 32'h00000000, 32'hFFFFFFFF, 32'h12345678, 32'h80000000};
      logic [31:0] py [6] = '{32'h00000001, 32'h00000001, 32'h00000000, 32'h7FFFFFFF, 32'h12345678, 32'h80000000};
      for (int p = 0; p < 6; p++) begin
        for (int c = 0; c < 32; c++) begin
          logic [31:0] er;
          logic ez, eo;
          ref_model(px[p], py[p], c[4], c[3:2], c[1:0], er, ez, eo);
          apply(px[p], py[p], c[4], c[3:2], c[1:0]);
          cmp1("sweep result", c[1:0] == 2'b00 ? 4 : c[1:0] == 2'b01 ? 5 :
                               c[1:0] == 2'b10 ? (c[4] ? 2 : 1) : 3, result, er);
          cmp1("sweep is_zero", 9, {31'd0, is_zero}, {31'd0, ez});
          cmp1("sweep ovf", c[4] ? 8 : 7, {31'd0, ovf}, {31'd0, eo});
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule